// File: doc/BRIEF.md
# Serial Mode-Register Port

This block is a four-wire serial slave that lets a host controller program and read back a small bank of 8-bit configuration registers. The host selects the block by pulling its select line low. It then clocks exactly one 16-bit frame, most significant bit first. The frame carries a direction flag, a 7-bit register index and one data byte. The register bank lives inside the block, comes out of reset with parameter-given values, and is presented as one flat parallel bus to the logic it configures.

The serial lines are not used as clocks. The select, serial clock and data input are brought into the system clock domain through synchronizers, and the serial clock edges are found by comparing successive samples. The system clock must therefore run several times faster than the serial clock. Only indices in a parameterised window `BASE_IDX .. BASE_IDX+NUM_REGS-1` are backed by storage. Every other index reads as zero and absorbs writes.

Top module: `spi_mode_port`

## Requirements
- R1: After reset, `regs_flat` holds `RESET_VALUES` (register at index BASE_IDX+k in bits k*8+7..k*8) and `spi_miso` is 0.
- R2: A frame is 16 bits, MSB first, sampled on rising `spi_sclk`. Bit 15 = 0 selects write, bits 14:8 are the index and bits 7:0 are the data. After the 16th rising edge the indexed register takes the data byte.
- R3: During a write frame no register output changes before the 16th rising serial clock edge.
- R4: If `spi_csn` rises before 16 rising edges have been seen, the frame is dropped and no register changes.
- R5: In a frame with bit 15 = 1, `spi_miso` presents the indexed register MSB first. Each bit is updated on the falling edge that follows rising edges 8 through 15, so the host samples data bits 7..0 at rising edges 9..16.
- R6: `spi_miso` is 0 while `spi_csn` is high, during the first 8 bits of any frame, and throughout write frames.
- R7: A write to an index outside the implemented window changes no register, and a read of such an index returns 0x00.
- R8: Serial clock edges after the 16th are ignored until `spi_csn` has gone high and low again. A second frame clocked without deselecting has no effect.
- R9: A read frame leaves every register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, several times the serial clock rate |
| rst_n | input | 1 | Synchronous active-low reset |
| spi_csn | input | 1 | Select, active low, asynchronous to clk |
| spi_sclk | input | 1 | Serial clock from the host, asynchronous to clk |
| spi_mosi | input | 1 | Serial data from the host |
| spi_miso | output | 1 | Serial readback data to the host |
| regs_flat | output | NUM_REGS*8 | Parallel contents of the register bank |

## Verification
The bench aims at the boundaries of the index window: the lowest and highest backed index, and the neighbours just outside it. A design with an off-by-one decode would either corrupt a real register or return non-zero data for an absent one. It shortens frames to every length from 1 to 15 bits. A design that commits on a partial count would change a register there. It also clocks up to 32 bits under one select, which exposes a design that keeps shifting after bit 16 and lands a second write. Readback is sampled at the host's rising edges, so a block that drives its data one edge late or early returns a shifted byte. Random traffic then checks reads and writes against a bench model of the bank.

// File: rtl/spi_mode_port_pkg.sv
// Package: constants and types shared by the serial mode-register port.
// Assumes a fixed 16-bit frame: one command byte then one data byte.
package spi_mode_port_pkg;
    localparam int FRAME_BITS = 16;
    localparam int CMD_BITS   = 8;
    localparam int CNT_W      = $clog2(FRAME_BITS + 1);

    typedef enum logic [1:0] {
        FR_IDLE  = 2'd0,
        FR_SHIFT = 2'd1,
        FR_DONE  = 2'd2
    } frame_state_t;
endpackage

// File: rtl/spi_mode_port_sync.sv
// Module: multi-bit, multi-stage synchronizer for independent slow inputs.
// Assumes each bit is a level that is held for many clk periods; bits are
// not guaranteed to cross together, so the caller must tolerate skew.
module spi_mode_port_sync #(
    parameter int               WIDTH     = 3,
    parameter int               STAGES    = 2,
    parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                // First flop: captures the asynchronous levels.
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[0] <= RESET_VAL;
                    else        stage_q[0] <= async_in;
                end
            end else begin : g_next
                // Later flops: resolve metastability one stage at a time.
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[s] <= RESET_VAL;
                    else        stage_q[s] <= stage_q[s-1];
                end
            end
        end
    endgenerate

    assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/spi_mode_port_frame.sv
// Module: frame engine. It finds serial clock edges in the clk domain,
// shifts in the command and data bytes, drives readback bits and raises a
// one-cycle write strobe after the 16th rising edge.
// Assumes synchronized inputs with equal latency on all three lines.
module spi_mode_port_frame
    import spi_mode_port_pkg::*;
#(
    parameter int IDX_W  = 7,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              csn_s,
    input  logic              sclk_s,
    input  logic              mosi_s,
    input  logic [DATA_W-1:0] rd_data,
    output logic [IDX_W-1:0]  idx_q,
    output logic              rd_frame,
    output logic              wr_fire,
    output logic [DATA_W-1:0] wr_data,
    output logic [CNT_W-1:0]  bit_cnt,
    output logic              miso_q
);
    localparam logic [CNT_W-1:0] LAST_CMD  = CNT_W'(CMD_BITS - 1);
    localparam logic [CNT_W-1:0] FIRST_OUT = CNT_W'(CMD_BITS);
    localparam logic [CNT_W-1:0] LAST_BIT  = CNT_W'(FRAME_BITS - 1);

    frame_state_t        state_q;
    logic                sclk_d, csn_d;
    logic                sclk_rise, sclk_fall, cs_fall;
    logic [DATA_W-2:0]   shift_q;
    logic [DATA_W-1:0]   tx_q;
    logic [DATA_W-1:0]   byte_now;

    assign sclk_rise = sclk_s & ~sclk_d;
    assign sclk_fall = ~sclk_s & sclk_d;
    assign cs_fall   = ~csn_s & csn_d;
    assign byte_now  = {shift_q, mosi_s};

    // Edge history: previous samples of the synchronized clock and select.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_d <= 1'b0;
            csn_d  <= 1'b1;
        end else begin
            sclk_d <= sclk_s;
            csn_d  <= csn_s;
        end
    end

    // Frame sequencing: bit count, command decode, readback and write strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= FR_IDLE;
            bit_cnt  <= '0;
            shift_q  <= '0;
            tx_q     <= '0;
            idx_q    <= '0;
            rd_frame <= 1'b0;
            wr_fire  <= 1'b0;
            wr_data  <= '0;
            miso_q   <= 1'b0;
        end else begin
            wr_fire <= 1'b0;
            if (csn_s) begin
                state_q  <= FR_IDLE;
                bit_cnt  <= '0;
                rd_frame <= 1'b0;
                miso_q   <= 1'b0;
            end else begin
                unique case (state_q)
                    FR_IDLE: begin
                        if (cs_fall) begin
                            state_q  <= FR_SHIFT;
                            bit_cnt  <= '0;
                            rd_frame <= 1'b0;
                        end
                    end
                    FR_SHIFT: begin
                        if (sclk_rise) begin
                            shift_q <= byte_now[DATA_W-2:0];
                            bit_cnt <= bit_cnt + 1'b1;
                            if (bit_cnt == LAST_CMD) begin
                                rd_frame <= byte_now[DATA_W-1];
                                idx_q    <= byte_now[IDX_W-1:0];
                            end
                            if (bit_cnt == LAST_BIT) begin
                                state_q <= FR_DONE;
                                wr_fire <= ~rd_frame;
                                wr_data <= byte_now;
                            end
                        end else if (sclk_fall && rd_frame) begin
                            if (bit_cnt == FIRST_OUT) begin
                                miso_q <= rd_data[DATA_W-1];
                                tx_q   <= {rd_data[DATA_W-2:0], 1'b0};
                            end else begin
                                miso_q <= tx_q[DATA_W-1];
                                tx_q   <= {tx_q[DATA_W-2:0], 1'b0};
                            end
                        end
                    end
                    FR_DONE: begin
                        if (sclk_fall) miso_q <= 1'b0;
                    end
                    default: state_q <= FR_IDLE;
                endcase
            end
        end
    end
endmodule

// File: rtl/spi_mode_port_file.sv
// Module: register bank. It holds NUM_REGS bytes at indices BASE_IDX and up,
// writes one of them on a strobe, and reads by index with zero for misses.
// Assumes wr_en is a single-cycle pulse with index and data stable.
module spi_mode_port_file #(
    parameter int                           IDX_W        = 7,
    parameter int                           DATA_W       = 8,
    parameter int                           NUM_REGS     = 8,
    parameter int                           BASE_IDX     = 16,
    parameter logic [NUM_REGS*DATA_W-1:0]   RESET_VALUES = '0
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [IDX_W-1:0]           wr_idx,
    input  logic [DATA_W-1:0]          wr_byte,
    input  logic [IDX_W-1:0]           rd_idx,
    output logic [DATA_W-1:0]          rd_byte,
    output logic [NUM_REGS*DATA_W-1:0] regs_flat
);
    generate
        for (genvar k = 0; k < NUM_REGS; k++) begin : g_reg
            localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(BASE_IDX + k);
            logic [DATA_W-1:0] val_q;
            // Storage for one register; loads only on a matching write.
            always_ff @(posedge clk) begin
                if (!rst_n)                         val_q <= RESET_VALUES[k*DATA_W +: DATA_W];
                else if (wr_en && wr_idx == MY_IDX) val_q <= wr_byte;
            end
            assign regs_flat[k*DATA_W +: DATA_W] = val_q;
        end
    endgenerate

    // Readback mux: OR of the single matching register, zero if none matches.
    always_comb begin
        rd_byte = '0;
        for (int k = 0; k < NUM_REGS; k++) begin
            if (rd_idx == IDX_W'(BASE_IDX + k)) rd_byte = regs_flat[k*DATA_W +: DATA_W];
        end
    end
endmodule

// File: rtl/spi_mode_port.sv
// Module: top of the serial mode-register port. It chains the input
// synchronizer, the frame engine and the register bank.
// Assumes clk is at least about 8x the serial clock, so that each serial
// level lasts several clk periods after synchronization.
module spi_mode_port
    import spi_mode_port_pkg::*;
#(
    parameter int                         NUM_REGS     = 8,
    parameter int                         BASE_IDX     = 16,
    parameter int                         SYNC_STAGES  = 2,
    parameter logic [NUM_REGS*8-1:0]      RESET_VALUES = '0
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  spi_csn,
    input  logic                  spi_sclk,
    input  logic                  spi_mosi,
    output logic                  spi_miso,
    output logic [NUM_REGS*8-1:0] regs_flat
);
    localparam int IDX_W  = FRAME_BITS - CMD_BITS - 1;
    localparam int DATA_W = FRAME_BITS - CMD_BITS;

    logic [2:0]        pins_s;
    logic [IDX_W-1:0]  idx_q;
    logic              rd_frame;
    logic              wr_fire;
    logic [DATA_W-1:0] wr_data;
    logic [DATA_W-1:0] rd_data;
    logic [CNT_W-1:0]  bit_cnt;

    spi_mode_port_sync #(
        .WIDTH     (3),
        .STAGES    (SYNC_STAGES),
        .RESET_VAL (3'b100)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in ({spi_csn, spi_sclk, spi_mosi}),
        .sync_out (pins_s)
    );

    spi_mode_port_frame #(
        .IDX_W  (IDX_W),
        .DATA_W (DATA_W)
    ) u_frame (
        .clk      (clk),
        .rst_n    (rst_n),
        .csn_s    (pins_s[2]),
        .sclk_s   (pins_s[1]),
        .mosi_s   (pins_s[0]),
        .rd_data  (rd_data),
        .idx_q    (idx_q),
        .rd_frame (rd_frame),
        .wr_fire  (wr_fire),
        .wr_data  (wr_data),
        .bit_cnt  (bit_cnt),
        .miso_q   (spi_miso)
    );

    spi_mode_port_file #(
        .IDX_W        (IDX_W),
        .DATA_W       (DATA_W),
        .NUM_REGS     (NUM_REGS),
        .BASE_IDX     (BASE_IDX),
        .RESET_VALUES (RESET_VALUES)
    ) u_file (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_fire),
        .wr_idx    (idx_q),
        .wr_byte   (wr_data),
        .rd_idx    (idx_q),
        .rd_byte   (rd_data),
        .regs_flat (regs_flat)
    );
endmodule

// File: rtl/spi_mode_port_chk.sv
// Module: assertion checker bound to spi_mode_port. It relates the write
// strobe from the frame engine to the register bank outputs and to miso.
// Assumes the default 7-bit index and 8-bit data layout.
module spi_mode_port_chk #(
    parameter int NUM_REGS = 8,
    parameter int BASE_IDX = 16
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  miso,
    input logic [NUM_REGS*8-1:0] regs_flat,
    input logic                  wr_fire,
    input logic [6:0]            wr_idx,
    input logic [7:0]            wr_data,
    input logic                  rd_frame,
    input logic [4:0]            bit_cnt
);
    logic        hit;
    logic [31:0] slot;

    assign hit  = (int'(wr_idx) >= BASE_IDX) && (int'(wr_idx) < BASE_IDX + NUM_REGS);
    assign slot = hit ? 32'(int'(wr_idx) - BASE_IDX) : 32'd0;

    a_r2_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_fire && hit) |=> (regs_flat[$past(slot)*8 +: 8] == $past(wr_data)));

    a_r3_change_needs_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(regs_flat) |-> $past(wr_fire));

    a_r7_miss_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_fire && !hit) |=> $stable(regs_flat));

    a_r6_quiet_unless_read: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_frame |-> !miso);

    a_r9_read_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        rd_frame |-> !wr_fire);

    a_r8_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        bit_cnt <= 5'd16);
endmodule

bind spi_mode_port spi_mode_port_chk #(
    .NUM_REGS (NUM_REGS),
    .BASE_IDX (BASE_IDX)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .miso      (spi_miso),
    .regs_flat (regs_flat),
    .wr_fire   (wr_fire),
    .wr_idx    (idx_q),
    .wr_data   (wr_data),
    .rd_frame  (rd_frame),
    .bit_cnt   (bit_cnt)
);

// File: tb/spi_mode_port_test.sv
module spi_mode_port_test;
    localparam int          NREG = 8;
    localparam int          BASE = 16;
    localparam logic [63:0] RSTV = 64'h5A00_3C11_FF80_017E;
    localparam int          HALF = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        csn = 1'b1, sclk = 1'b0, mosi = 1'b0;
    logic        miso;
    logic [63:0] regs;
    logic [63:0] model;
    int          total = 0, failed = 0;
    logic        done = 1'b0;

    always #2.5 clk = ~clk;

    spi_mode_port #(.NUM_REGS(NREG), .BASE_IDX(BASE), .SYNC_STAGES(2), .RESET_VALUES(RSTV)) uut (
        .clk(clk), .rst_n(rst_n), .spi_csn(csn), .spi_sclk(sclk),
        .spi_mosi(mosi), .spi_miso(miso), .regs_flat(regs));

    function automatic logic is_hit(input logic [6:0] idx);
        return (int'(idx) >= BASE) && (int'(idx) < BASE + NREG);
    endfunction

    function automatic logic [7:0] exp_read(input logic [6:0] idx);
        return is_hit(idx) ? model[(int'(idx) - BASE)*8 +: 8] : 8'h00;
    endfunction

    task automatic check(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            failed++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    // One select window with nclk serial clocks; bits sent from bits[31] down.
    task automatic frame(input logic [31:0] bits, input int nclk,
                         output logic [7:0] rd, output logic cmd_hi,
                         output logic any_hi, output logic pre_ok);
        rd = '0; cmd_hi = 1'b0; any_hi = 1'b0; pre_ok = 1'b1;
        @(negedge clk); csn = 1'b0;
        wait_clk(HALF);
        for (int i = 0; i < nclk; i++) begin
            mosi = bits[31 - i];
            wait_clk(HALF);
            if (i < 8 && miso) cmd_hi = 1'b1;
            if (miso) any_hi = 1'b1;
            if (i >= 8 && i < 16) rd[15 - i] = miso;
            if (i == 15 && regs !== model) pre_ok = 1'b0;
            sclk = 1'b1;
            wait_clk(HALF);
            sclk = 1'b0;
        end
        wait_clk(HALF);
        if (miso) any_hi = 1'b1;
        csn = 1'b1;
        wait_clk(2*HALF);
    endtask

    task automatic do_write(input logic [6:0] idx, input logic [7:0] data, input string req);
        logic [7:0] rd; logic ch, ah, pre;
        frame({1'b0, idx, data, 16'h0}, 16, rd, ch, ah, pre);
        check(pre, "R3", regs, model);
        check(!ah, "R6", {63'd0, ah}, 64'd0);
        if (is_hit(idx)) model[(int'(idx) - BASE)*8 +: 8] = data;
        check(regs === model, req, regs, model);
    endtask

    task automatic do_read(input logic [6:0] idx, input string req);
        logic [7:0] rd; logic ch, ah, pre;
        logic [7:0] exp;
        exp = exp_read(idx);
        frame({1'b1, idx, 8'hA5, 16'h0}, 16, rd, ch, ah, pre);
        check(rd === exp, req, {56'd0, rd}, {56'd0, exp});
        check(!ch, "R6", {63'd0, ch}, 64'd0);
        check(regs === model, "R9", regs, model);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++; failed++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", total - failed, total);
            $finish;
        end
    end

    initial begin
        logic [7:0] rd; logic ch, ah, pre;
        int seed;
        seed = $urandom(32'd20240611);
        model = RSTV;
        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(3);
        check(regs === RSTV, "R1", regs, RSTV);
        check(miso === 1'b0, "R1", {63'd0, miso}, 64'd0);

        // R2 / R7 window edges
        do_write(7'd16, 8'hC3, "R2");
        do_write(7'd23, 8'h29, "R2");
        do_write(7'd15, 8'hEE, "R7");
        do_write(7'd24, 8'h77, "R7");
        do_read(7'd16, "R5");
        do_read(7'd23, "R5");
        do_read(7'd15, "R7");
        do_read(7'd127, "R7");
        check(miso === 1'b0, "R6", {63'd0, miso}, 64'd0);

        // R4 truncated frames of every length
        for (int n = 1; n < 16; n++) begin
            frame({1'b0, 7'd18, 8'h5F, 16'h0}, n, rd, ch, ah, pre);
            check(regs === model, "R4", regs, model);
        end

        // R8 a second frame without deselect has no effect
        frame({1'b0, 7'd19, 8'h12, 1'b0, 7'd20, 8'h34}, 32, rd, ch, ah, pre);
        model[3*8 +: 8] = 8'h12;
        check(regs === model, "R8", regs, model);
        frame({1'b0, 7'd21, 8'h9D, 16'hFFFF}, 20, rd, ch, ah, pre);
        model[5*8 +: 8] = 8'h9D;
        check(regs === model, "R8", regs, model);

        // Random traffic
        for (int t = 0; t < 60; t++) begin
            logic [6:0] idx;
            logic [7:0] dat;
            idx = 7'($urandom_range(12, 27));
            dat = 8'($urandom);
            if ($urandom_range(0, 1) == 0) do_write(idx, dat, is_hit(idx) ? "R2" : "R7");
            else do_read(idx, is_hit(idx) ? "R5" : "R7");
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", total - failed, total);
        $finish;
    end
endmodule